// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is a first-in first-out buffer, 64 words deep and 36 bits wide. It moves data in one direction, from a write port to a read port. Each port runs on its own free-running clock. The two clocks may be unrelated, or they may be the very same net. Each port has three gating inputs: a select, a direction and an enable. A word is stored or fetched on a rising edge of that port's clock only when all three gating inputs agree and the buffer can take the transfer.

The write side reports two flags, full and almost-full. The read side reports two flags, empty and almost-empty. Each port keeps a Gray-coded pointer. The pointer reaches the opposite clock domain through a two-stage synchroniser, and every flag is computed there and registered in the clock of the port that uses it.

The margin for the two "almost" flags is fixed at reset. A two-bit select input is sampled while reset is held. Its value picks one of four offsets, and that offset is shared by both almost flags.

Top module: `xferFifo`

## Requirements
- R1: While `rstN` is low, and at the first sample after its release, `full`=0, `almostFull`=0, `empty`=1, `almostEmpty`=1 and `rdData`=0. Reset acts asynchronously.
- R2: A word is stored at a rising `wrClk` edge only when all of the following hold: `wrSel`=1, `wrDir`=1, `wrEn`=1 and `full`=0. Any other combination of these inputs stores nothing.
- R3: A word is fetched at a rising `rdClk` edge only when all of the following hold: `rdSel`=1, `rdDir`=0, `rdEn`=1 and `empty`=0. `rdData` changes only on such a fetch and otherwise holds its value.
- R4: Words leave in exactly the order they were accepted, with no word lost or duplicated.
- R5: `full` is 1 when the write-side count equals 64. The write-side count is the write pointer minus the synchronised read pointer. A write attempted while `full`=1 is dropped, and the stored contents stay unchanged.
- R6: `empty` is 1 when the read-side count is 0. The read-side count is the synchronised write pointer minus the read pointer. A read attempted while `empty`=1 leaves `rdData` and the stored contents unchanged.
- R7: `thrSel` is captured on clock edges while `rstN` is low. The value selects the offset: 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 4 words. Changes to `thrSel` after reset have no effect.
- R8: `almostFull` is 1 when the write-side count is at least 64 minus the offset. `almostEmpty` is 1 when the read-side count is at most the offset.
- R9: Each pointer crosses into the other domain through two synchroniser stages. With one shared clock:
  - a word written at edge k clears `empty` right after edge k+3;
  - a word read at edge k lowers the write-side count right after edge k+3.
- R10: A write and a read requested on the same edge of a shared clock are both accepted whenever the flags allow each of them.
- R11: With unrelated write and read clocks, every accepted word comes out intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-port clock |
| rdClk | input | 1 | Read-port clock |
| rstN | input | 1 | Asynchronous reset, active low |
| thrSel | input | 2 | Almost-flag offset select, captured during reset |
| wrSel | input | 1 | Write-port select, active high |
| wrDir | input | 1 | Write-port direction, 1 = store |
| wrEn | input | 1 | Write-port enable, active high |
| wrData | input | 36 | Word to store |
| full | output | 1 | No free location (write clock) |
| almostFull | output | 1 | Free locations at or below the offset (write clock) |
| rdSel | input | 1 | Read-port select, active high |
| rdDir | input | 1 | Read-port direction, 0 = fetch |
| rdEn | input | 1 | Read-port enable, active high |
| rdData | output | 36 | Last fetched word |
| empty | output | 1 | No stored word (read clock) |
| almostEmpty | output | 1 | Stored words at or below the offset (read clock) |

## Verification
The bench checks the latency of the synchroniser exactly. It runs one shared clock and counts the edges from a write until `empty` falls. A design that skipped a stage, or added one, would clear `empty` one edge too early or too late. The bench also overfills the buffer and over-drains it. A design that failed to block writes while full would overwrite unread words, and one that failed to block reads while empty would replay stale data or wrap the read pointer. Both faults show up as `rdData` mismatches against the queue model. The bench moves `thrSel` after reset to catch a design that samples it continuously instead of at reset. It also tries every single-input miss of the port gating, to catch a transfer that should have been refused. A final phase runs the two clocks at unrelated periods to expose a pointer that crosses domains in binary instead of Gray code.

// File: rtl/xferFifoPkg.sv
`timescale 1ns/1ps
package xferFifoPkg;
  // Per-cycle transfer strobes from control to datapath
  typedef struct packed {
    logic wrStb;   // accepted write, wrClk domain
    logic rdStb;   // accepted read, rdClk domain
  } fifoStb_t;
endpackage

// File: rtl/xferFifoSync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a Gray-coded pointer; emits the binary form
module xferFifoSync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= grayIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  // Gray to binary: each bit is the XOR of itself and all higher bits
  for (genvar g = 0; g < W; g++) begin : gBit
    assign binOut[g] = ^stage[STAGES-1][W-1:g];
  end
endmodule

// File: rtl/xferFifoCtl.sv
`timescale 1ns/1ps
module xferFifoCtl
  import xferFifoPkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic [1:0]    thrSel,
  input  logic          wrSel,
  input  logic          wrDir,
  input  logic          wrEn,
  input  logic          rdSel,
  input  logic          rdDir,
  input  logic          rdEn,
  output fifoStb_t      stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          full,
  output logic          almostFull,
  output logic          empty,
  output logic          almostEmpty
);
  localparam int OFF_STEP = DEPTH / 16;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] offsetOf(input logic [1:0] s);
    return PW'((4 - int'(s)) * OFF_STEP);
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, wrBinNext, rdSyncBin, wrCountNext, wrOff;
  logic [1:0]    wrOffSel;
  logic          wrReq;

  // offset select is captured only while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) wrOffSel <= thrSel;
  end

  assign wrOff       = offsetOf(wrOffSel);
  assign wrReq       = wrSel & wrDir & wrEn;
  assign stb.wrStb   = wrReq & ~full;
  assign wrBinNext   = wrBin + PW'(stb.wrStb);
  assign wrCountNext = wrBinNext - rdSyncBin;
  assign wrAddr      = wrBin[AW-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      full       <= 1'b0;
      almostFull <= 1'b0;
    end else begin
      wrBin      <= wrBinNext;
      wrGray     <= wrBinNext ^ (wrBinNext >> 1);
      full       <= (wrCountNext == DEPTH_P);
      almostFull <= (wrCountNext >= DEPTH_P - wrOff);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNext, wrSyncBin, rdCountNext, rdOff;
  logic [1:0]    rdOffSel;
  logic          rdReq;

  always_ff @(posedge rdClk) begin
    if (!rstN) rdOffSel <= thrSel;
  end

  assign rdOff       = offsetOf(rdOffSel);
  assign rdReq       = rdSel & ~rdDir & rdEn;
  assign stb.rdStb   = rdReq & ~empty;
  assign rdBinNext   = rdBin + PW'(stb.rdStb);
  assign rdCountNext = wrSyncBin - rdBinNext;
  assign rdAddr      = rdBin[AW-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      empty       <= 1'b1;
      almostEmpty <= 1'b1;
    end else begin
      rdBin       <= rdBinNext;
      rdGray      <= rdBinNext ^ (rdBinNext >> 1);
      empty       <= (rdCountNext == '0);
      almostEmpty <= (rdCountNext <= rdOff);
    end
  end

  // ---------------- pointer crossings ----------------
  xferFifoSync #(.W(PW), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk(wrClk), .rstN(rstN), .grayIn(rdGray), .binOut(rdSyncBin));

  xferFifoSync #(.W(PW), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk(rdClk), .rstN(rstN), .grayIn(wrGray), .binOut(wrSyncBin));
endmodule

// File: rtl/xferFifoDp.sv
`timescale 1ns/1ps
module xferFifoDp
  import xferFifoPkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/xferFifo.sv
`timescale 1ns/1ps
module xferFifo
  import xferFifoPkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [1:0]        thrSel,
  input  logic              wrSel,
  input  logic              wrDir,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  output logic              almostFull,
  input  logic              rdSel,
  input  logic              rdDir,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty
);
  localparam int AW = $clog2(DEPTH);

  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;

  xferFifoCtl #(.DEPTH(DEPTH), .SYNC_STAGES(2)) uCtl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .thrSel(thrSel),
    .wrSel(wrSel), .wrDir(wrDir), .wrEn(wrEn),
    .rdSel(rdSel), .rdDir(rdDir), .rdEn(rdEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty));

  xferFifoDp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData));
endmodule

// File: rtl/xferFifoChk.sv
`timescale 1ns/1ps
module xferFifoChk #(
  parameter int DATA_W = 36
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrSel,
  input logic              wrDir,
  input logic              wrEn,
  input logic              rdSel,
  input logic              rdDir,
  input logic              rdEn,
  input logic              full,
  input logic              almostFull,
  input logic              empty,
  input logic              almostEmpty,
  input logic [DATA_W-1:0] rdData
);
  AST_FULL_NEEDS_AF: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull); // R8

  AST_EMPTY_NEEDS_AE: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty); // R8

  AST_FULL_RISE_ON_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(full) |-> $past(wrSel && wrDir && wrEn)); // R5

  AST_EMPTY_RISE_ON_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(empty) |-> $past(rdSel && !rdDir && rdEn)); // R6

  AST_RDDATA_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    !(rdSel && !rdDir && rdEn) |=> $stable(rdData)); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |=> $stable(rdData)); // R6
endmodule

bind xferFifo xferFifoChk #(.DATA_W(DATA_W)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrSel(wrSel), .wrDir(wrDir), .wrEn(wrEn),
  .rdSel(rdSel), .rdDir(rdDir), .rdEn(rdEn),
  .full(full), .almostFull(almostFull),
  .empty(empty), .almostEmpty(almostEmpty), .rdData(rdData));

// File: tb/sim_xferFifo.sv
`timescale 1ns/1ps
module sim_xferFifo;
  localparam int DW = 36;
  localparam int DEPTH = 64;

  logic wrClk = 0, slowClk = 0, asyncMode = 0;
  logic rdClk;
  always #4 wrClk = ~wrClk;          // 125 MHz
  always #5.65 slowClk = ~slowClk;   // unrelated read clock
  assign rdClk = asyncMode ? slowClk : wrClk;

  logic rstN = 0;
  logic [1:0] thrSel = 0;
  logic wSel = 0, wDir = 0, wEn = 0, rSel = 0, rDir = 1, rEn = 0;
  logic [DW-1:0] wData = '0;
  logic full, almostFull, empty, almostEmpty;
  logic [DW-1:0] rdData;

  xferFifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .thrSel(thrSel),
    .wrSel(wSel), .wrDir(wDir), .wrEn(wEn), .wrData(wData),
    .full(full), .almostFull(almostFull),
    .rdSel(rSel), .rdDir(rDir), .rdEn(rEn), .rdData(rdData),
    .empty(empty), .almostEmpty(almostEmpty));

  int nTests = 0, nFail = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference (shared clock only) ----------------
  bit modelOn = 0;
  logic [DW-1:0] q[$];
  int wCnt = 0, rCnt = 0, rS1 = 0, rS2 = 0, wS1 = 0, wS2 = 0, mOff = 16, bothCnt = 0;
  bit mFull = 0, mAF = 0, mEmpty = 1, mAE = 1;
  logic [DW-1:0] mRd = '0;

  always @(posedge wrClk) begin
    if (!asyncMode) begin
      if (!rstN) begin
        mOff = (4 - int'(thrSel)) * (DEPTH / 16);
        wCnt = 0; rCnt = 0; rS1 = 0; rS2 = 0; wS1 = 0; wS2 = 0;
        mFull = 0; mAF = 0; mEmpty = 1; mAE = 1; mRd = '0;
        q.delete();
      end else begin
        bit wAcc, rAcc;
        int oldW, oldR, fc, ec;
        wAcc = wSel && wDir && wEn && !mFull;
        rAcc = rSel && !rDir && rEn && !mEmpty;
        if (wAcc && rAcc) bothCnt++;
        if (rAcc) mRd = q.pop_front();
        if (wAcc) q.push_back(wData);
        oldW = wCnt; oldR = rCnt;
        wCnt += int'(wAcc); rCnt += int'(rAcc);
        fc = wCnt - rS2;            // read pointer seen two stages late
        ec = wS2 - rCnt;            // write pointer seen two stages late
        rS2 = rS1; rS1 = oldR; wS2 = wS1; wS1 = oldW;
        mFull = (fc == DEPTH); mAF = (fc >= DEPTH - mOff);
        mEmpty = (ec == 0);    mAE = (ec <= mOff);
      end
    end
  end

  always @(negedge wrClk) begin
    if (!asyncMode && modelOn) begin
      chk(full === mFull, "R5 full", 64'(full), 64'(mFull));
      chk(empty === mEmpty, "R6 empty", 64'(empty), 64'(mEmpty));
      chk(almostFull === mAF, "R8 almostFull", 64'(almostFull), 64'(mAF));
      chk(almostEmpty === mAE, "R8 almostEmpty", 64'(almostEmpty), 64'(mAE));
      chk(rdData === mRd, "R4 rdData", 64'(rdData), 64'(mRd));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(input bit ws, wd, we, input bit rs, rd, re);
    @(negedge wrClk); #1;
    wSel = ws; wDir = wd; wEn = we; wData = DW'({$urandom(), $urandom()});
    rSel = rs; rDir = rd; rEn = re;
  endtask

  task automatic step(input bit w, input bit r);
    drv(w, 1'b1, w, r, 1'b0, r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic doReset(input logic [1:0] sel, input bit am);
    @(negedge wrClk); #1;
    rstN = 0; thrSel = sel; asyncMode = am;
    wSel = 0; wEn = 0; rSel = 0; rEn = 0;
    repeat (4) @(negedge wrClk);
    modelOn = 1;
    #1 rstN = 1;
  endtask

  // ---------------- unrelated-clock phase ----------------
  localparam int NASYNC = 300;

  task automatic asyncWriter();
    int sent = 0;
    while (sent < NASYNC) begin
      @(negedge wrClk);
      if (!full) begin
        wSel = 1; wDir = 1; wEn = 1; wData = DW'(sent * 7 + 3); sent++;
      end else begin
        wEn = 0;
      end
    end
    @(negedge wrClk); wEn = 0;
  endtask

  task automatic asyncReader();
    int got = 0;
    bit pend = 0;
    while (got < NASYNC) begin
      @(negedge rdClk);
      if (pend) begin
        chk(rdData === DW'(got * 7 + 3), "R11 async order", 64'(rdData), 64'(got * 7 + 3));
        got++;
      end
      pend = !empty && (got < NASYNC);
      rSel = 1; rDir = 0; rEn = pend;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [DW-1:0] firstWord;

    doReset(2'd0, 1'b0);
    @(negedge wrClk);
    chk(full === 0 && almostFull === 0, "R1 write flags", {full, almostFull}, 0);
    chk(empty === 1 && almostEmpty === 1, "R1 read flags", {empty, almostEmpty}, 3);
    chk(rdData === '0, "R1 rdData", rdData, 0);

    // R9: single write, empty must fall exactly after edge k+3
    step(1'b1, 1'b0);
    firstWord = wData;
    for (int i = 0; i < 3; i++) begin
      @(negedge wrClk);
      chk(empty === 1, "R9 empty held", empty, 1);
      #1 wEn = 0; wSel = 0;
    end
    @(negedge wrClk);
    chk(empty === 0, "R9 empty falls", empty, 0);

    // R2/R3: each single gating miss
    drv(0, 1, 1, 0, 0, 1);
    drv(1, 0, 1, 1, 1, 1);
    drv(1, 1, 0, 1, 0, 0);
    idle(4);
    chk(rdData === '0, "R3 gated reads ignored", rdData, 0);
    step(1'b0, 1'b1);
    idle(4);
    chk(rdData === firstWord, "R4 first word", rdData, firstWord);
    chk(empty === 1, "R2 gated writes ignored", empty, 1);

    // R7: offset 16 from reset; later thrSel change has no effect
    thrSel = 2'd3;
    for (int i = 0; i < 47; i++) step(1'b1, 1'b0);
    idle(4);
    chk(almostFull === 0, "R7 47 words below threshold", almostFull, 0);
    step(1'b1, 1'b0);
    idle(4);
    chk(almostFull === 1, "R7 48 words at threshold", almostFull, 1);

    // R5: overfill
    for (int i = 0; i < 22; i++) step(1'b1, 1'b0);
    idle(4);
    chk(full === 1, "R5 full after overfill", full, 1);

    // R6: over-drain
    for (int i = 0; i < 70; i++) step(1'b0, 1'b1);
    idle(4);
    chk(empty === 1 && rdData === mRd, "R6 drain and hold", rdData, mRd);

    // R10/R4: mixed traffic
    for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, ($urandom % 3) != 0);
    idle(4);
    chk(bothCnt > 0, "R10 simultaneous transfers", 64'(bothCnt), 1);

    // R7/R8: offset 4
    doReset(2'd3, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    idle(4);
    chk(almostEmpty === 1, "R8 4 words almost empty", almostEmpty, 1);
    step(1'b1, 1'b0);
    idle(4);
    chk(almostEmpty === 0, "R8 5 words not almost empty", almostEmpty, 0);
    for (int i = 0; i < 54; i++) step(1'b1, 1'b0);
    idle(4);
    chk(almostFull === 0, "R7 59 words offset 4", almostFull, 0);
    step(1'b1, 1'b0);
    idle(4);
    chk(almostFull === 1, "R7 60 words offset 4", almostFull, 1);

    // R11: unrelated clocks
    modelOn = 0;
    doReset(2'd0, 1'b1);
    fork
      asyncWriter();
      asyncReader();
    join
    repeat (4) @(negedge rdClk);
    chk(empty === 1, "R11 drained", empty, 1);

    finishRun();
  end
endmodule